// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Engine

This block is the target side of a two-wire serial memory. A fast system clock oversamples the serial clock and data lines. The block drives one output, a pull-down enable for the open-drain data line. It finds start and stop conditions on the bus. It accepts an address byte that carries a fixed type code, strap bits and a direction bit. It then serves byte writes, page writes, current-address reads, random reads and sequential reads from a small on-chip byte array.

Write data goes into a page buffer first. The array is updated only when a stop condition closes the write. The update then runs as a timed internal cycle whose length, in system clocks, is a parameter. During that cycle the block ignores the bus entirely, so a controller finds out that the cycle has ended by polling for an acknowledge. A write-protect input held high at the stop discards the buffered data. When the word address is wider than eight bits, its upper bits come from the strap field of the address byte, and fewer strap pins are compared.

Top module: `ee2w_target`

## Requirements
- R1: After reset the pull-down enable is low and the block waits for a start condition.
- R2: An address byte whose upper nibble is 1010 and whose bits 3..1 match `strap_i` on every compared position is acknowledged: the data line is held low during the ninth clock. Bit 0 of that byte selects the direction, with 1 for read and 0 for write.
- R3: An address byte with a different upper nibble, or with a strap mismatch, is not acknowledged. The block then leaves the line released until the next start.
- R4: In a write, the byte after the address byte loads the word pointer. A later random read returns the byte written at that address. A random read is a write-direction address, a word address, a repeated start and a read-direction address.
- R5: In a page write, successive data bytes go to successive offsets within one page of 2^PAGE_W bytes, and the offset wraps inside that page. A byte sent after more than a page of bytes overwrites earlier data of the same page.
- R6: In a sequential read the block sends the next byte each time the controller acknowledges. The pointer wraps from the last array address to address 0.
- R7: A current-address read returns the byte at the address after the last byte that was accessed.
- R8: After a write that ends in a stop, the block acknowledges nothing, not even its own address, for WR_CYC system clocks. After that it acknowledges again.
- R9: When `wp_i` is high at the stop, the write is discarded, the array keeps its contents and no timed cycle starts.
- R10: A start that arrives before a stop cancels the buffered write data, and no timed cycle follows.
- R11: A read byte that the controller does not acknowledge ends the read. The block drives nothing on the clocks that follow.
- R12: The pull-down enable changes only while the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than the serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND bus value) |
| strap_i | input | 3 | Strap pins compared with bits 3..1 of the address byte |
| wp_i | input | 1 | Write protect, high blocks array updates |
| sda_pd_o | output | 1 | Pull-down enable for the open-drain data line |

## Verification
A table of byte writes walks addresses that spread over the array, including both ends. Each byte is read back by random read, which separates correct pointer loading from stale-pointer reads. A nine-byte page write that starts at an offset inside the page shows whether the offset wraps within the page or carries into the next one. A sequential read across the top address shows whether the full pointer wraps. Polling right after a stop, a protected write and a write cut short by a repeated start each separate a committed update from a discarded one. A wrong type code and a wrong strap code each separate a match from a mismatch.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_WADR, ST_WDAT, ST_ACK, ST_RDAT, ST_RACK
  } ee2w_st_e;
endpackage

// File: rtl/ee2w_sync.sv
module ee2w_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] raw, s1, s2, s3;
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1[g] <= 1'b1;
        s2[g] <= 1'b1;
        s3[g] <= 1'b1;
      end else begin
        s1[g] <= raw[g];
        s2[g] <= s1[g];
        s3[g] <= s2[g];
      end
    end
  end

  assign sda_o      = s2[0];
  assign scl_rise_o = s2[1] & ~s3[1];
  assign scl_fall_o = ~s2[1] & s3[1];
  assign start_o    = s2[1] & s3[1] & s3[0] & ~s2[0];
  assign stop_o     = s2[1] & s3[1] & ~s3[0] & s2[0];
endmodule

// File: rtl/ee2w_store.sv
module ee2w_store #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [7:0]               rd_data_o,
  input  logic                     cap_en_i,
  input  logic [PAGE_W-1:0]        cap_off_i,
  input  logic [7:0]               cap_data_i,
  input  logic                     clr_i,
  input  logic                     commit_i,
  input  logic [ADDR_W-PAGE_W-1:0] base_i
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int HI_W  = ADDR_W - PAGE_W;

  logic [7:0]        arr  [DEPTH];
  logic [7:0]        pbuf [PAGE];
  logic [PAGE-1:0]   vld;
  logic              cm_act;
  logic [PAGE_W-1:0] cm_idx;
  logic [HI_W-1:0]   cm_base;
  logic              we;

  assign we = cm_act & vld[cm_idx];

  always_ff @(posedge clk_i) begin
    rd_data_o <= arr[rd_addr_i];
    if (we) arr[{cm_base, cm_idx}] <= pbuf[cm_idx];
    if (cap_en_i) pbuf[cap_off_i] <= cap_data_i;
  end

  // one buffered byte per clock is copied out during the busy window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld     <= '0;
      cm_act  <= 1'b0;
      cm_idx  <= '0;
      cm_base <= '0;
    end else if (cm_act) begin
      cm_idx <= cm_idx + 1'b1;
      if (cm_idx == PAGE_W'(PAGE - 1)) begin
        cm_act <= 1'b0;
        vld    <= '0;
      end
    end else if (commit_i) begin
      cm_act  <= 1'b1;
      cm_idx  <= '0;
      cm_base <= base_i;
    end else if (clr_i) begin
      vld <= '0;
    end else if (cap_en_i) begin
      vld[cap_off_i] <= 1'b1;
    end
  end
endmodule

// File: rtl/ee2w_ctrl.sv
module ee2w_ctrl
  import ee2w_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 3,
  parameter int WR_CYC = 50000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sda_i,
  input  logic                     scl_rise_i,
  input  logic                     scl_fall_i,
  input  logic                     start_i,
  input  logic                     stop_i,
  input  logic [2:0]               strap_i,
  input  logic                     wp_i,
  input  logic [7:0]               rd_data_i,
  output logic                     pd_o,
  output logic                     busy_o,
  output logic [ADDR_W-1:0]        rd_addr_o,
  output logic                     cap_en_o,
  output logic [PAGE_W-1:0]        cap_off_o,
  output logic [7:0]               cap_data_o,
  output logic                     clr_o,
  output logic                     commit_o,
  output logic [ADDR_W-PAGE_W-1:0] base_o
);
  localparam int PG_BITS = (ADDR_W > 8) ? ADDR_W - 8 : 0;
  localparam logic [2:0] CMP_MASK = 3'(3'b111 << PG_BITS);
  localparam int CNT_W = $clog2(WR_CYC + 1);

  ee2w_st_e          st, nxt;
  logic [3:0]        bitc;
  logic [7:0]        sh, tx;
  logic [ADDR_W-1:0] ptr, wadr;
  logic [2:0]        devpg;
  logic              pend, mack;
  logic [CNT_W-1:0]  busy_cnt;
  logic              addr_hit, byte_done;

  assign busy_o     = busy_cnt != '0;
  assign rd_addr_o  = ptr;
  assign cap_off_o  = ptr[PAGE_W-1:0];
  assign cap_data_o = sh;
  assign base_o     = ptr[ADDR_W-1:PAGE_W];
  assign byte_done  = scl_fall_i && bitc == 4'd8;
  assign clr_o      = start_i & ~busy_o;
  assign cap_en_o   = (st == ST_WDAT) & byte_done & ~busy_o & ~start_i & ~stop_i;
  assign commit_o   = stop_i & ~busy_o & ~start_i & pend & ~wp_i;
  assign addr_hit   = sh[7:4] == 4'b1010 && ((sh[3:1] ^ strap_i) & CMP_MASK) == 3'b000;

  if (ADDR_W > 8) begin : g_pg
    assign wadr = {devpg[PG_BITS-1:0], sh};
  end else begin : g_nopg
    assign wadr = sh[ADDR_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE; nxt <= ST_IDLE; bitc <= '0; sh <= '0; tx <= '0;
      ptr <= '0; devpg <= '0; pend <= 1'b0; mack <= 1'b0;
      busy_cnt <= '0; pd_o <= 1'b0;
    end else if (busy_o) begin
      busy_cnt <= busy_cnt - 1'b1;
    end else if (start_i) begin
      st <= ST_DEV; bitc <= '0; pd_o <= 1'b0; pend <= 1'b0;
    end else if (stop_i) begin
      st <= ST_IDLE; pd_o <= 1'b0; pend <= 1'b0;
      if (pend && !wp_i) busy_cnt <= CNT_W'(WR_CYC);
    end else begin
      case (st)
        ST_DEV, ST_WADR, ST_WDAT: begin
          if (scl_rise_i) begin
            sh   <= {sh[6:0], sda_i};
            bitc <= bitc + 1'b1;
          end else if (byte_done) begin
            pd_o <= 1'b1;
            st   <= ST_ACK;
            if (st == ST_DEV) begin
              devpg <= sh[3:1];
              nxt   <= sh[0] ? ST_RDAT : ST_WADR;
              if (!addr_hit) begin
                pd_o <= 1'b0;
                st   <= ST_IDLE;
              end
            end else if (st == ST_WADR) begin
              ptr <= wadr;
              nxt <= ST_WDAT;
            end else begin
              pend <= 1'b1;
              ptr  <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
              nxt  <= ST_WDAT;
            end
          end
        end
        ST_ACK: if (scl_fall_i) begin
          bitc <= '0;
          st   <= nxt;
          if (nxt == ST_RDAT) begin
            tx   <= rd_data_i;
            pd_o <= ~rd_data_i[7];
            ptr  <= ptr + 1'b1;
          end else begin
            pd_o <= 1'b0;
          end
        end
        ST_RDAT: begin
          if (scl_rise_i) begin
            bitc <= bitc + 1'b1;
          end else if (byte_done) begin
            pd_o <= 1'b0;
            st   <= ST_RACK;
          end else if (scl_fall_i) begin
            tx   <= tx << 1;
            pd_o <= ~tx[6];
          end
        end
        ST_RACK: begin
          if (scl_rise_i) begin
            mack <= ~sda_i;
          end else if (scl_fall_i) begin
            if (mack) begin
              tx   <= rd_data_i;
              pd_o <= ~rd_data_i[7];
              ptr  <= ptr + 1'b1;
              bitc <= '0;
              st   <= ST_RDAT;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ee2w_target.sv
module ee2w_target #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 3,
  parameter int WR_CYC = 50000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_pd_o
);
  localparam int HI_W = ADDR_W - PAGE_W;

  logic              sda_s, scl_rise, scl_fall, start_p, stop_p, wr_busy;
  logic [7:0]        rd_data, cap_data;
  logic [ADDR_W-1:0] rd_addr;
  logic              cap_en, clr, commit;
  logic [PAGE_W-1:0] cap_off;
  logic [HI_W-1:0]   base;

  ee2w_sync u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_p), .stop_o(stop_p)
  );

  ee2w_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYC(WR_CYC)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_p), .stop_i(stop_p), .strap_i(strap_i), .wp_i(wp_i),
    .rd_data_i(rd_data), .pd_o(sda_pd_o), .busy_o(wr_busy),
    .rd_addr_o(rd_addr), .cap_en_o(cap_en), .cap_off_o(cap_off),
    .cap_data_o(cap_data), .clr_o(clr), .commit_o(commit), .base_o(base)
  );

  ee2w_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .cap_en_i(cap_en), .cap_off_i(cap_off), .cap_data_i(cap_data),
    .clr_i(clr), .commit_i(commit), .base_i(base)
  );
endmodule

// File: rtl/ee2w_target_chk.sv
module ee2w_target_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic wp_i,
  input logic sda_pd_o,
  input logic busy_i,
  input logic start_i,
  input logic stop_i
);
  // R12: line drive moves only in the clock-low phase
  p_pd_scl_low_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_pd_o != $past(sda_pd_o)) |-> !scl_i);

  // R8: no acknowledge of any kind while the internal cycle runs
  p_busy_silent_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !sda_pd_o);

  // R9: the timed cycle never begins from a protected stop
  p_wp_no_cycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> !$past(wp_i));

  // R10: a start releases the line
  p_start_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !sda_pd_o);

  // R11: a stop releases the line
  p_stop_release_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_pd_o);
endmodule

bind ee2w_target ee2w_target_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .wp_i(wp_i),
  .sda_pd_o(sda_pd_o), .busy_i(wr_busy), .start_i(start_p), .stop_i(stop_p)
);

// File: tb/ee2w_target_tb.sv
module ee2w_target_tb;
  localparam int CLK_NS = 10;
  localparam int Q      = 8 * CLK_NS;
  localparam int WR_CYC = 600;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};
  // {word address, data}
  localparam logic [15:0] VEC [8] = '{
    16'h00_3C, 16'h01_A5, 16'h7F_00, 16'hFF_77,
    16'h13_5A, 16'hC4_81, 16'hFE_12, 16'h14_E7};

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_pd, line;
  int n_chk = 0, n_fail = 0, r12_bad = 0;

  assign line = sda_m & ~sda_pd;
  always #(CLK_NS / 2) clk = ~clk;

  ee2w_target #(.WR_CYC(WR_CYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(line),
    .strap_i(STRAP), .wp_i(wp), .sda_pd_o(sda_pd));

  always @(sda_pd) if (rst_n && scl) r12_bad++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic b_start();
    sda_m = 1'b1; #(Q); scl = 1'b1; #(Q); sda_m = 1'b0; #(Q); scl = 1'b0; #(Q);
  endtask
  task automatic b_stop();
    sda_m = 1'b0; #(Q); scl = 1'b1; #(Q); sda_m = 1'b1; #(Q);
  endtask
  task automatic wbit(logic b);
    sda_m = b; #(Q); scl = 1'b1; #(2 * Q); scl = 1'b0; #(Q);
  endtask
  task automatic rbit(output logic b);
    sda_m = 1'b1; #(Q); scl = 1'b1; #(Q); b = line; #(Q); scl = 1'b0; #(Q);
  endtask
  task automatic send(logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b);
    ack = ~b;
  endtask
  task automatic recv(output logic [7:0] d, input logic give_ack);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(~give_ack);
  endtask
  task automatic wait_ready(output int polls);
    logic a;
    polls = 0;
    for (int i = 0; i < 40; i++) begin
      b_start(); send(DEV_W, a); b_stop();
      polls++;
      if (a) break;
    end
  endtask
  task automatic byte_write(logic [7:0] adr, logic [7:0] d, string req);
    logic a0, a1, a2;
    b_start(); send(DEV_W, a0); send(adr, a1); send(d, a2); b_stop();
    check({req, " write acks"}, {a0, a1, a2}, 3'b111);
  endtask
  task automatic rand_read_start(logic [7:0] adr, string req);
    logic a0, a1, a2;
    b_start(); send(DEV_W, a0); send(adr, a1); b_start(); send(DEV_R, a2);
    check({req, " dummy-write acks"}, {a0, a1, a2}, 3'b111);
  endtask

  initial begin : watchdog
    #(CLK_NS * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic a, a2;
    logic [7:0] d;
    int polls;
    #(3 * CLK_NS);
    @(negedge clk);
    check("R1 pd in reset", sda_pd, 1'b0);
    rst_n = 1'b1;
    #(10 * CLK_NS);
    check("R1 pd after reset", sda_pd, 1'b0);

    // R3: wrong type code, then wrong strap code, then a trailing byte
    b_start(); send(8'hB0 | {STRAP, 1'b0}, a); b_stop();
    check("R3 bad type nack", a, 1'b0);
    b_start(); send({4'b1010, 3'b100, 1'b0}, a); send(8'h00, a2); b_stop();
    check("R3 bad strap nack", a, 1'b0);
    check("R3 silent after mismatch", a2, 1'b0);

    // R2 / R4 / R8: vector walk
    for (int i = 0; i < 8; i++) begin
      byte_write(VEC[i][15:8], VEC[i][7:0], "R2");
      wait_ready(polls);
      check("R8 busy after stop", polls > 1, 1'b1);
      check("R8 ready again", polls < 40, 1'b1);
      rand_read_start(VEC[i][15:8], "R4");
      recv(d, 1'b0); b_stop();
      check("R4 random read", d, VEC[i][7:0]);
    end

    // R7: last random read was 0x14, so pointer sits at 0x15; use 0x13 -> 0x14
    rand_read_start(8'h13, "R7"); recv(d, 1'b0); b_stop();
    b_start(); send(DEV_R, a); recv(d, 1'b0); b_stop();
    check("R7 current address read", d, 8'hE7);

    // R5: nine bytes from offset 1 of page 0x20
    b_start(); send(DEV_W, a); send(8'h21, a);
    for (int k = 0; k < 9; k++) send(8'h90 + 8'(k), a);
    b_stop();
    wait_ready(polls);
    rand_read_start(8'h20, "R5");
    for (int k = 0; k < 8; k++) begin
      recv(d, k != 7);
      check("R5 page wrap", d, (k == 0) ? 8'h97 : (k == 1) ? 8'h98 : 8'h8F + 8'(k));
    end
    b_stop();

    // R6: sequential read across the top of the array; R11 after the nack
    rand_read_start(8'hFE, "R6");
    recv(d, 1'b1); check("R6 seq 0xFE", d, 8'h12);
    recv(d, 1'b1); check("R6 seq 0xFF", d, 8'h77);
    recv(d, 1'b0); check("R6 wrap to 0x00", d, 8'h3C);
    recv(d, 1'b0); b_stop();
    check("R11 released after nack", d, 8'hFF);

    // R9: protected write
    wp = 1'b1;
    byte_write(8'h01, 8'h11, "R9");
    b_start(); send(DEV_W, a); b_stop();
    check("R9 no timed cycle", a, 1'b1);
    wp = 1'b0;
    rand_read_start(8'h01, "R9"); recv(d, 1'b0); b_stop();
    check("R9 array unchanged", d, 8'hA5);

    // R10: write cut short by a repeated start
    b_start(); send(DEV_W, a); send(8'h7F, a); send(8'h55, a);
    b_start(); send(DEV_W, a); b_stop();
    check("R10 no timed cycle", a, 1'b1);
    rand_read_start(8'h7F, "R10"); recv(d, 1'b0); b_stop();
    check("R10 write cancelled", d, 8'h00);

    check("R12 pd moved with scl high", r12_bad, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule